// File: doc/BRIEF.md
# Data-Transfer Decoder and Effective-Address Unit

This unit sits in the execute stage of a 16-bit-instruction integer core. Each cycle it can accept one instruction word. It recognises the register-displacement, R0-indexed, global-base-relative and PC-relative data-transfer forms. For each form it produces a registered memory request, made up of the direction, the size code, a 32-bit effective address and the store data. It also produces the destination register index and a write-back enable.

The register file is outside the unit. It supplies the value of the register named in instruction bits [7:4] on `rm_val`, the register named in bits [11:8] on `rn_val`, and R0 on `r0_val`. The global base register and the program counter arrive on their own inputs. All results appear one cycle after acceptance.

In that output cycle, the memory returns its read data on `mem_rdata`. The unit then forms the 32-bit write-back value from it:
- a byte or word load is sign-extended;
- a longword load passes through unchanged;
- the PC-relative address form returns the computed address itself.

Top module: `ldst_agu`

## Requirements
- R1: While reset is held and after it is released with no valid input, `out_valid`, `mem_req`, `mem_we`, `wb_en` and `unsupported` are 0.
- R2: An instruction accepted with `in_valid`=1 at a rising edge shows all of its results from that edge until the next one, with `out_valid`=1. If `in_valid`=0, the next cycle has `out_valid`=0 and no request, write-back or unsupported flag, whatever `insn` holds.
- R3: Word 1000_0101_mmmm_dddd loads a word (size 01) from `rm_val`+d·2 into register 0. Word 0101_nnnn_mmmm_dddd loads a longword (size 10) from `rm_val`+d·4 into register n.
- R4: Word 0000_nnnn_mmmm_01ss, with ss in {00,01,10}, stores `rm_val` on `mem_wdata` at `r0_val`+`rn_val`. The size code is ss (00 byte, 01 word, 10 long), `mem_we`=1 and `wb_en`=0.
- R5: Word 0000_nnnn_mmmm_11ss, with ss in {00,01,10}, loads size ss from `r0_val`+`rm_val` into register n.
- R6: Word 1100_00ss_dddddddd, with ss in {00,01,10}, stores `r0_val` at `gbr_val`+(d<<ss) with size code ss.
- R7: Word 1100_01ss_dddddddd, with ss in {00,01,10}, loads size ss from `gbr_val`+(d<<ss) into register 0.
- R8: Word 1100_0111_dddddddd makes no memory request. It asserts `wb_en` with `rd_idx`=0 and `wb_data`=`pc_val`+d·4.
- R9: In a load's output cycle, `wb_data` holds the value from `mem_rdata`. For a byte load it is bits [7:0] sign-extended, for a word load bits [15:0] sign-extended, and for a longword load all 32 bits.
- R10: A valid word that matches none of the forms above sets `unsupported`=1 with `mem_req`=0 and `wb_en`=0.
- R11: Displacement fields are zero-extended before scaling, so an all-ones displacement adds its full positive scaled value.
- R12: The effective address sum wraps modulo 2^32.
- R13: `mem_we` is 1 only together with `mem_req`, and loads never assert `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| insn | input | 16 | Instruction word |
| rm_val | input | 32 | Value of the register named by insn[7:4] |
| rn_val | input | 32 | Value of the register named by insn[11:8] |
| r0_val | input | 32 | Value of register 0 |
| gbr_val | input | 32 | Global base register |
| pc_val | input | 32 | Program counter for the PC-relative form |
| mem_rdata | input | 32 | Read data returned in the output cycle |
| out_valid | output | 1 | Registered result valid |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Access is a store |
| mem_size | output | 2 | 00 byte, 01 word, 10 long |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Store data, full register value |
| rd_idx | output | 4 | Write-back register index |
| wb_en | output | 1 | Write-back requested |
| wb_data | output | 32 | Extended load data or computed address |
| unsupported | output | 1 | Valid word outside the transfer group |

## Verification
The hardest case to reach from the ports is the sign boundary of a load. It depends on data that the memory returns only after the address has been formed. The bench's memory model derives `mem_rdata` from `mem_addr`, so the stimulus chooses register and displacement values that place the address with bit 7 or bit 15 either clear or set. This drives the returned byte or word to both sides of its sign bit. Every-ones displacements combined with base values near 2^32 reach zero-extension and wraparound together. Instructions are sent back to back and between idle cycles that carry valid-looking words.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int INSN_W = 16;
    localparam int RIDX_W = 4;
    localparam int DISP_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } xfer_size_e;

    typedef enum logic [1:0] {
        BASE_RM  = 2'd0,
        BASE_RN  = 2'd1,
        BASE_GBR = 2'd2,
        BASE_PC  = 2'd3
    } base_sel_e;

    typedef enum logic {
        OFF_DISP = 1'b0,
        OFF_R0   = 1'b1
    } off_sel_e;

    typedef struct packed {
        logic              legal;
        logic              mem_req;
        logic              mem_we;
        xfer_size_e        size;
        base_sel_e         base;
        off_sel_e          off;
        logic [DISP_W-1:0] disp;
        logic [RIDX_W-1:0] rd;
        logic              wb;
        logic              sdata_r0;
    } dec_t;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    logic [3:0] op_hi;
    logic [3:0] fld_n;
    logic [3:0] fld_lo;
    logic [1:0] sz_lo;
    logic [1:0] sz_mid;

    assign op_hi  = insn[15:12];
    assign fld_n  = insn[11:8];
    assign fld_lo = insn[3:0];
    assign sz_lo  = insn[1:0];
    assign sz_mid = insn[9:8];

    always_comb begin
        dec = '0;
        case (op_hi)
            4'h8: begin
                if (fld_n == 4'h5) begin
                    dec.legal   = 1'b1;
                    dec.mem_req = 1'b1;
                    dec.size    = SZ_WORD;
                    dec.base    = BASE_RM;
                    dec.off     = OFF_DISP;
                    dec.disp    = {4'b0000, fld_lo};
                    dec.rd      = '0;
                    dec.wb      = 1'b1;
                end
            end
            4'h5: begin
                dec.legal   = 1'b1;
                dec.mem_req = 1'b1;
                dec.size    = SZ_LONG;
                dec.base    = BASE_RM;
                dec.off     = OFF_DISP;
                dec.disp    = {4'b0000, fld_lo};
                dec.rd      = fld_n;
                dec.wb      = 1'b1;
            end
            4'h0: begin
                if (fld_lo[3:2] == 2'b01 && sz_lo != 2'b11) begin
                    dec.legal   = 1'b1;
                    dec.mem_req = 1'b1;
                    dec.mem_we  = 1'b1;
                    dec.size    = xfer_size_e'(sz_lo);
                    dec.base    = BASE_RN;
                    dec.off     = OFF_R0;
                end else if (fld_lo[3:2] == 2'b11 && sz_lo != 2'b11) begin
                    dec.legal   = 1'b1;
                    dec.mem_req = 1'b1;
                    dec.size    = xfer_size_e'(sz_lo);
                    dec.base    = BASE_RM;
                    dec.off     = OFF_R0;
                    dec.rd      = fld_n;
                    dec.wb      = 1'b1;
                end
            end
            4'hC: begin
                if (fld_n[3:2] == 2'b00 && sz_mid != 2'b11) begin
                    dec.legal    = 1'b1;
                    dec.mem_req  = 1'b1;
                    dec.mem_we   = 1'b1;
                    dec.size     = xfer_size_e'(sz_mid);
                    dec.base     = BASE_GBR;
                    dec.off      = OFF_DISP;
                    dec.disp     = insn[7:0];
                    dec.sdata_r0 = 1'b1;
                end else if (fld_n[3:2] == 2'b01) begin
                    dec.legal = 1'b1;
                    dec.off   = OFF_DISP;
                    dec.disp  = insn[7:0];
                    dec.rd    = '0;
                    dec.wb    = 1'b1;
                    if (sz_mid != 2'b11) begin
                        dec.mem_req = 1'b1;
                        dec.size    = xfer_size_e'(sz_mid);
                        dec.base    = BASE_GBR;
                    end else begin
                        dec.size    = SZ_LONG;
                        dec.base    = BASE_PC;
                    end
                end
            end
            default: dec = '0;
        endcase
    end

endmodule

// File: rtl/ldst_addr.sv
module ldst_addr
    import ldst_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  base_sel_e         base,
    input  off_sel_e          off,
    input  xfer_size_e        size,
    input  logic [DISP_W-1:0] disp,
    input  logic [XLEN-1:0]   rm_val,
    input  logic [XLEN-1:0]   rn_val,
    input  logic [XLEN-1:0]   r0_val,
    input  logic [XLEN-1:0]   gbr_val,
    input  logic [XLEN-1:0]   pc_val,
    output logic [XLEN-1:0]   addr
);

    localparam int SHMAX = 2;

    logic [XLEN-1:0] base_v;
    logic [XLEN-1:0] disp_z;
    logic [XLEN-1:0] disp_sc [SHMAX+1];
    logic [XLEN-1:0] off_v;

    assign disp_z = XLEN'(disp);

    for (genvar s = 0; s <= SHMAX; s++) begin : g_scale
        assign disp_sc[s] = disp_z << s;
    end

    always_comb begin
        case (base)
            BASE_RM:  base_v = rm_val;
            BASE_RN:  base_v = rn_val;
            BASE_GBR: base_v = gbr_val;
            default:  base_v = pc_val;
        endcase
    end

    always_comb begin
        if (off == OFF_R0) begin
            off_v = r0_val;
        end else begin
            case (size)
                SZ_BYTE: off_v = disp_sc[0];
                SZ_WORD: off_v = disp_sc[1];
                default: off_v = disp_sc[2];
            endcase
        end
    end

    assign addr = base_v + off_v;

endmodule

// File: rtl/ldst_loadext.sv
module ldst_loadext
    import ldst_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_size_e      size,
    input  logic [XLEN-1:0] rdata,
    output logic [XLEN-1:0] ext
);

    localparam int BW = 8;
    localparam int HW = 16;

    always_comb begin
        case (size)
            SZ_BYTE: ext = {{(XLEN-BW){rdata[BW-1]}}, rdata[BW-1:0]};
            SZ_WORD: ext = {{(XLEN-HW){rdata[HW-1]}}, rdata[HW-1:0]};
            default: ext = rdata;
        endcase
    end

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [XLEN-1:0]   rm_val,
    input  logic [XLEN-1:0]   rn_val,
    input  logic [XLEN-1:0]   r0_val,
    input  logic [XLEN-1:0]   gbr_val,
    input  logic [XLEN-1:0]   pc_val,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              out_valid,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [RIDX_W-1:0] rd_idx,
    output logic              wb_en,
    output logic [XLEN-1:0]   wb_data,
    output logic              unsupported
);

    typedef struct packed {
        logic              valid;
        logic              mem_req;
        logic              mem_we;
        xfer_size_e        size;
        logic [XLEN-1:0]   addr;
        logic [XLEN-1:0]   wdata;
        logic [RIDX_W-1:0] rd;
        logic              wb;
        logic              is_load;
        logic              unsup;
    } out_t;

    dec_t            dec;
    logic [XLEN-1:0] agen_addr;
    logic [XLEN-1:0] ld_ext;
    out_t            out_d;
    out_t            out_q;

    ldst_decode u_decode (
        .insn (insn),
        .dec  (dec)
    );

    ldst_addr #(.XLEN(XLEN)) u_addr (
        .base    (dec.base),
        .off     (dec.off),
        .size    (dec.size),
        .disp    (dec.disp),
        .rm_val  (rm_val),
        .rn_val  (rn_val),
        .r0_val  (r0_val),
        .gbr_val (gbr_val),
        .pc_val  (pc_val),
        .addr    (agen_addr)
    );

    ldst_loadext #(.XLEN(XLEN)) u_ext (
        .size  (out_q.size),
        .rdata (mem_rdata),
        .ext   (ld_ext)
    );

    always_comb begin
        out_d = '0;
        if (in_valid) begin
            out_d.valid   = 1'b1;
            out_d.unsup   = !dec.legal;
            out_d.mem_req = dec.mem_req;
            out_d.mem_we  = dec.mem_we;
            out_d.size    = dec.mem_req ? dec.size : SZ_BYTE;
            out_d.addr    = dec.legal ? agen_addr : '0;
            out_d.wdata   = dec.mem_we ? (dec.sdata_r0 ? r0_val : rm_val) : '0;
            out_d.rd      = dec.wb ? dec.rd : '0;
            out_d.wb      = dec.wb;
            out_d.is_load = dec.mem_req && !dec.mem_we;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid   = out_q.valid;
    assign mem_req     = out_q.mem_req;
    assign mem_we      = out_q.mem_we;
    assign mem_size    = out_q.size;
    assign mem_addr    = out_q.addr;
    assign mem_wdata   = out_q.wdata;
    assign rd_idx      = out_q.rd;
    assign wb_en       = out_q.wb;
    assign unsupported = out_q.unsup;
    assign wb_data     = !out_q.wb ? '0 : (out_q.is_load ? ld_ext : out_q.addr);

endmodule

// File: rtl/ldst_agu_chk.sv
module ldst_agu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic       mem_req,
    input logic       mem_we,
    input logic [1:0] mem_size,
    input logic [3:0] rd_idx,
    input logic       wb_en,
    input logic       unsupported
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || wb_en || unsupported) |-> out_valid);

    assert_store_no_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !wb_en);

    assert_size_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_size != 2'b11);

    assert_pcrel_to_r0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && wb_en && !mem_req) |-> rd_idx == 4'd0);

    assert_load_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> wb_en);

    assert_unsup_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (!mem_req && !wb_en));

    assert_we_needs_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

endmodule

bind ldst_agu ldst_agu_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_size    (mem_size),
    .rd_idx      (rd_idx),
    .wb_en       (wb_en),
    .unsupported (unsupported)
);

// File: tb/ldst_agu_bench.sv
`timescale 1ns/1ps
module ldst_agu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] insn = '0;
    logic [31:0] rm_val = '0, rn_val = '0, r0_val = '0, gbr_val = '0, pc_val = '0;
    logic [31:0] mem_rdata;
    logic        out_valid, mem_req, mem_we, wb_en, unsupported;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata, wb_data;
    logic [3:0]  rd_idx;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [31:0] memval(input logic [31:0] a);
        return a ^ 32'hA5A5_8080;
    endfunction

    assign mem_rdata = memval(mem_addr);

    ldst_agu u_ldst_agu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .rm_val(rm_val), .rn_val(rn_val), .r0_val(r0_val), .gbr_val(gbr_val),
        .pc_val(pc_val), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_idx(rd_idx),
        .wb_en(wb_en), .wb_data(wb_data), .unsupported(unsupported)
    );

    typedef struct {
        logic        req, we, wb, unsup;
        logic [1:0]  size;
        logic [31:0] addr, wdata, wbd;
        logic [3:0]  rd;
        string       tag;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sext(input logic [31:0] v, input logic [1:0] s);
        if (s == 2'b00) return {{24{v[7]}}, v[7:0]};
        if (s == 2'b01) return {{16{v[15]}}, v[15:0]};
        return v;
    endfunction

    function automatic exp_t model(input logic [15:0] i, input logic [31:0] rm, rn, r0, gbr, pc,
                                   input string tag);
        exp_t e;
        e.req = 0; e.we = 0; e.wb = 0; e.unsup = 1; e.size = 0;
        e.addr = 0; e.wdata = 0; e.wbd = 0; e.rd = 0; e.tag = tag;
        if (i[15:8] == 8'h85) begin
            e.unsup = 0; e.req = 1; e.wb = 1; e.size = 2'b01;
            e.addr = rm + {27'd0, i[3:0], 1'b0}; e.rd = 0;
        end else if (i[15:12] == 4'h5) begin
            e.unsup = 0; e.req = 1; e.wb = 1; e.size = 2'b10;
            e.addr = rm + {26'd0, i[3:0], 2'b00}; e.rd = i[11:8];
        end else if (i[15:12] == 4'h0 && (i[3:0] == 4'h4 || i[3:0] == 4'h5 || i[3:0] == 4'h6)) begin
            e.unsup = 0; e.req = 1; e.we = 1; e.size = i[1:0];
            e.addr = r0 + rn; e.wdata = rm;
        end else if (i[15:12] == 4'h0 && (i[3:0] == 4'hC || i[3:0] == 4'hD || i[3:0] == 4'hE)) begin
            e.unsup = 0; e.req = 1; e.wb = 1; e.size = i[1:0];
            e.addr = r0 + rm; e.rd = i[11:8];
        end else if (i[15:10] == 6'b1100_00 && i[9:8] != 2'b11) begin
            e.unsup = 0; e.req = 1; e.we = 1; e.size = i[9:8];
            e.addr = gbr + ({24'd0, i[7:0]} << i[9:8]); e.wdata = r0;
        end else if (i[15:10] == 6'b1100_01 && i[9:8] != 2'b11) begin
            e.unsup = 0; e.req = 1; e.wb = 1; e.size = i[9:8];
            e.addr = gbr + ({24'd0, i[7:0]} << i[9:8]); e.rd = 0;
        end else if (i[15:8] == 8'hC7) begin
            e.unsup = 0; e.wb = 1; e.rd = 0;
            e.wbd = pc + {22'd0, i[7:0], 2'b00};
        end
        if (e.req && !e.we) e.wbd = sext(memval(e.addr), e.size);
        return e;
    endfunction

    task automatic issue(input logic [15:0] i, input logic [31:0] rm, rn, r0, gbr, pc,
                         input string tag);
        @(negedge clk);
        in_valid = 1'b1; insn = i;
        rm_val = rm; rn_val = rn; r0_val = r0; gbr_val = gbr; pc_val = pc;
        sb.push_back(model(i, rm, rn, r0, gbr, pc, tag));
    endtask

    task automatic idle(input logic [15:0] i);
        @(negedge clk);
        in_valid = 1'b0; insn = i;
    endtask

    // Monitor: pops one expected item per captured instruction
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(out_valid == 1'b1, e.tag, "out_valid (R2)", 32'(out_valid), 32'd1);
                    chk(mem_req == e.req, e.tag, "mem_req", 32'(mem_req), 32'(e.req));
                    chk(mem_we == e.we, e.tag, "mem_we (R13)", 32'(mem_we), 32'(e.we));
                    chk(wb_en == e.wb, e.tag, "wb_en", 32'(wb_en), 32'(e.wb));
                    chk(unsupported == e.unsup, e.tag, "unsupported", 32'(unsupported), 32'(e.unsup));
                    if (e.req) begin
                        chk(mem_size == e.size, e.tag, "mem_size", 32'(mem_size), 32'(e.size));
                        chk(mem_addr == e.addr, e.tag, "mem_addr", mem_addr, e.addr);
                    end
                    if (e.we) chk(mem_wdata == e.wdata, e.tag, "mem_wdata", mem_wdata, e.wdata);
                    if (e.wb) begin
                        chk(rd_idx == e.rd, e.tag, "rd_idx", 32'(rd_idx), 32'(e.rd));
                        chk(wb_data == e.wbd, e.tag, "wb_data", wb_data, e.wbd);
                    end
                end else begin
                    chk(!out_valid && !mem_req && !wb_en && !unsupported, "R2", "idle outputs",
                        {28'd0, out_valid, mem_req, wb_en, unsupported}, 32'd0);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!out_valid && !mem_req && !mem_we && !wb_en && !unsupported, "R1", "reset outputs",
            {27'd0, out_valid, mem_req, mem_we, wb_en, unsupported}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !mem_req && !mem_we && !wb_en && !unsupported, "R1", "after release",
            {27'd0, out_valid, mem_req, mem_we, wb_en, unsupported}, 32'd0);

        // R3: register plus short displacement
        issue(16'h853F, 32'h0000_1000, 0, 0, 0, 0, "R3 word disp4");
        issue(16'h5725, 32'h0000_2000, 0, 0, 0, 0, "R3 long disp4");
        // R4: indexed stores
        issue(16'h0A34, 32'h1122_3344, 32'h0000_0100, 32'h0000_0010, 0, 0, "R4 store byte");
        issue(16'h0A35, 32'h5566_7788, 32'h0000_0200, 32'h0000_0020, 0, 0, "R4 store word");
        issue(16'h0A36, 32'h99AA_BBCC, 32'h0000_0300, 32'h0000_0030, 0, 0, "R4 store long");
        idle(16'h0A36); // R2: valid-looking word while not valid
        // R5: indexed loads
        issue(16'h0B2C, 32'h0000_4000, 0, 32'h0000_0004, 0, 0, "R5 load byte");
        issue(16'h0B2D, 32'h0000_4000, 0, 32'h0000_0008, 0, 0, "R5 load word");
        issue(16'h0B2E, 32'h0000_4000, 0, 32'h0000_000C, 0, 0, "R5 load long");
        // R6: base-relative stores
        issue(16'hC010, 0, 0, 32'hCAFE_F00D, 32'h0001_0000, 0, "R6 store byte");
        issue(16'hC110, 0, 0, 32'hCAFE_F00D, 32'h0001_0000, 0, "R6 store word");
        issue(16'hC210, 0, 0, 32'hCAFE_F00D, 32'h0001_0000, 0, "R6 store long");
        // R7: base-relative loads
        issue(16'hC420, 0, 0, 0, 32'h0002_0000, 0, "R7 load byte");
        issue(16'hC520, 0, 0, 0, 32'h0002_0000, 0, "R7 load word");
        issue(16'hC620, 0, 0, 0, 32'h0002_0000, 0, "R7 load long");
        idle(16'hC7FF);
        // R8: PC-relative address
        issue(16'hC710, 0, 0, 0, 0, 32'h0000_8000, "R8 pc rel");
        issue(16'hC7FF, 0, 0, 0, 0, 32'h0000_8002, "R8 pc rel max disp");
        // R9: sign boundaries on returned data
        issue(16'h0B2C, 32'h0000_5000, 0, 32'h0000_0000, 0, 0, "R9 byte negative");
        issue(16'h0B2C, 32'h0000_5000, 0, 32'h0000_0080, 0, 0, "R9 byte positive");
        issue(16'h0B2D, 32'h0000_0000, 0, 32'h0000_0000, 0, 0, "R9 word negative");
        issue(16'h0B2D, 32'h0000_8000, 0, 32'h0000_0000, 0, 0, "R9 word positive");
        issue(16'h5100, 32'h0000_0000, 0, 0, 0, 0, "R9 long passthrough");
        // R10: unsupported words
        issue(16'h0007, 0, 0, 0, 0, 0, "R10 group0 hole");
        issue(16'h6308, 0, 0, 0, 0, 0, "R10 other group");
        issue(16'hC3FF, 0, 0, 0, 0, 0, "R10 store size 11");
        issue(16'h8412, 0, 0, 0, 0, 0, "R10 group8 other");
        issue(16'hFFFF, 0, 0, 0, 0, 0, "R10 all ones");
        // R11: zero-extended displacements
        issue(16'hC6FF, 0, 0, 0, 32'h0003_0000, 0, "R11 disp8 long max");
        issue(16'hC4FF, 0, 0, 0, 32'h0003_0000, 0, "R11 disp8 byte max");
        issue(16'h850F, 32'h0000_0100, 0, 0, 0, 0, "R11 disp4 word max");
        // R12: wraparound
        issue(16'h5108, 32'hFFFF_FFF0, 0, 0, 0, 0, "R12 disp wrap");
        issue(16'h0A35, 32'h1234_5678, 32'hFFFF_FFFE, 32'h0000_0004, 0, 0, "R12 index wrap");
        issue(16'hC2FF, 0, 0, 32'h0000_0001, 32'hFFFF_FF00, 0, "R12 base wrap");
        idle(16'h0000);
        idle(16'h5000);
        idle(16'h0000);
        chk(sb.size() == 0, "R2", "all results seen", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule